// File: doc/BRIEF.md
# UART character queue and flag path

This block is the data path between a 32-bit register bus and the serial transmit and receive engines of a UART. Software writes characters into a transmit queue and reads received characters from a receive queue. Both go through one data register. A read-only flag register reports whether each queue is empty or full. A line-configuration register selects the character width and whether the queues run at full depth or collapse to a single holding entry. A control register carries a global enable and separate transmit and receive enables.

The serial engines are outside the block. The transmit engine takes characters through a valid/ready handshake. Once it has taken a character, that character belongs to the engine and completes even if the section is then switched off. The receive engine delivers characters through a valid/ready handshake. It holds `rx_busy_i` high while a character is in progress, so that a character begun while enabled is still accepted after the enable drops. Bus reads return data combinationally in the same cycle. Writes and read side effects take place at the clock edge.

Top module: `uart_fifo_path`

## Requirements
- R1: After reset the flag register reads 0x90 (both queues empty), and both the line-configuration and control registers read 0. This means character mode, 5-bit characters and everything disabled.
- R2: The flag register reports transmit-empty at bit 7, receive-full at bit 6, transmit-full at bit 5 and receive-empty at bit 4. All other bits read 0.
- R3: With the queue-enable bit (bit 4 of line configuration) at 1, each direction holds 16 characters in arrival order. Full is reported at 16 entries.
- R4: With the queue-enable bit at 0, each direction holds one character. Full is reported as soon as that one character is present.
- R5: A data-register write while transmit-full is set is dropped and leaves the queue unchanged.
- R6: A data-register read while receive-empty is set returns 0 and changes no state.
- R7: The character width is bits 6:5 of line configuration (00=5, 01=6, 10=7, 11=8 bits) and is driven on `wlen_o`. Written characters are cut to that width when queued. Received characters are cut to it and zero-extended into the low bits on read.
- R8: `tx_valid_o` is raised only while the global enable (control bit 0) and the transmit enable (control bit 8) are both 1 and the transmit queue is not empty. Transmit-empty depends only on the queue, so it is set as soon as the last character is taken by the engine.
- R9: `rx_en_o` is 1 when the global enable and the receive enable (control bit 9) are both 1. `rx_ready_o` is 0 whenever the receive queue is full.
- R10: While `rx_busy_i` is 1, a character in progress is accepted even after the receive section has been disabled.
- R11: The data register is at offset 0x00, flags at 0x18, line configuration at 0x2C and control at 0x30. A write to flags or to any other offset is ignored, and a read of an unmapped offset returns 0.
- R12: Bus read data is valid in the same cycle as `bus_rd_i`. The effects of a write or pop are visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| tx_valid_o | output | 1 | Character available for the transmit engine |
| tx_ready_i | input | 1 | Transmit engine takes the character |
| tx_data_o | output | 8 | Character offered to the transmit engine |
| rx_valid_i | input | 1 | Receive engine delivers a character |
| rx_ready_o | output | 1 | Receive queue accepts the character |
| rx_data_i | input | 8 | Delivered character |
| rx_busy_i | input | 1 | Receive engine is inside a character |
| rx_en_o | output | 1 | Receive engine may start new characters |
| wlen_o | output | 2 | Character width code for both engines |

## Verification
Register read data and the handshake outputs are combinational, so the bench samples them 1 ns after driving the inputs at a falling edge. This happens before the rising edge that commits any write, pop or push. Queue contents, flags and register values change at that rising edge, so every check on them is made at the following falling edge, one cycle after the stimulus. Each bus, transmit and receive operation lasts exactly one cycle, so the expected values form a plain sequence with no waiting loops.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  localparam int CHAR_W = 8;
  localparam int BUS_W  = 32;

  // register byte offsets
  localparam logic [7:0] OFS_DATA  = 8'h00;
  localparam logic [7:0] OFS_FLAGS = 8'h18;
  localparam logic [7:0] OFS_LINE  = 8'h2C;
  localparam logic [7:0] OFS_CTRL  = 8'h30;

  // flag bit positions
  localparam int FLG_TX_EMPTY = 7;
  localparam int FLG_RX_FULL  = 6;
  localparam int FLG_TX_FULL  = 5;
  localparam int FLG_RX_EMPTY = 4;

  // line configuration fields
  localparam int LN_WLEN_LO = 5;
  localparam int LN_QEN     = 4;

  // control fields
  localparam int CT_RX_EN   = 9;
  localparam int CT_TX_EN   = 8;
  localparam int CT_UART_EN = 0;

  typedef enum logic [1:0] {
    WL_5 = 2'b00,
    WL_6 = 2'b01,
    WL_7 = 2'b10,
    WL_8 = 2'b11
  } wlen_e;

  typedef struct packed {
    wlen_e wlen;
    logic  qen;
  } line_cfg_t;

  typedef struct packed {
    logic rx_en;
    logic tx_en;
    logic uart_en;
  } ctrl_cfg_t;

  function automatic logic [CHAR_W-1:0] wlen_mask(wlen_e w);
    logic [CHAR_W-1:0] m;
    case (w)
      WL_5:    m = 8'h1F;
      WL_6:    m = 8'h3F;
      WL_7:    m = 8'h7F;
      default: m = 8'hFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/uart_sync_fifo.sv
module uart_sync_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             single_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CW-1:0]    count_o
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    count_q;
  logic [CW-1:0]    cap;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // capacity collapses to one entry in character mode
  assign cap     = single_i ? CW'(1) : CW'(DEPTH);
  assign empty_o = (count_q == '0);
  assign full_o  = (count_q >= cap);
  assign count_o = count_q;
  assign rdata_o = mem_q[rd_ptr_q];

  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (count_q == $past(count_q))); // R5

  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> empty_o); // R6

  AST_DEPTH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!single_i && push_i && !pop_i && (count_q == CW'(DEPTH - 1))) |=> full_o); // R3

endmodule

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
  import uart_fifo_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output line_cfg_t         line_o,
  output ctrl_cfg_t         ctrl_o
);

  line_cfg_t line_q;
  ctrl_cfg_t ctrl_q;
  logic      wr_line, wr_ctrl;
  logic      unused_wdata;

  assign wr_line = wr_i && (addr_i == ADDR_W'(OFS_LINE));
  assign wr_ctrl = wr_i && (addr_i == ADDR_W'(OFS_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '{wlen: WL_5, qen: 1'b0};
      ctrl_q <= '0;
    end else begin
      if (wr_line) begin
        line_q.wlen <= wlen_e'(wdata_i[LN_WLEN_LO +: 2]);
        line_q.qen  <= wdata_i[LN_QEN];
      end
      if (wr_ctrl) begin
        ctrl_q.rx_en   <= wdata_i[CT_RX_EN];
        ctrl_q.tx_en   <= wdata_i[CT_TX_EN];
        ctrl_q.uart_en <= wdata_i[CT_UART_EN];
      end
    end
  end

  assign line_o = line_q;
  assign ctrl_o = ctrl_q;
  assign unused_wdata = ^{wdata_i[BUS_W-1:10], wdata_i[7], wdata_i[3:1]};

  AST_FLAGS_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i == ADDR_W'(OFS_FLAGS))) |=> ($stable(line_q) && $stable(ctrl_q))); // R11

endmodule

// File: rtl/uart_fifo_path.sv
module uart_fifo_path
  import uart_fifo_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [CHAR_W-1:0] tx_data_o,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [CHAR_W-1:0] rx_data_i,
  input  logic              rx_busy_i,
  output logic              rx_en_o,
  output logic [1:0]        wlen_o
);

  line_cfg_t         line;
  ctrl_cfg_t         ctrl;
  logic [CHAR_W-1:0] mask;

  logic              tx_push, tx_pop, tx_empty, tx_full;
  logic [CHAR_W-1:0] tx_head;
  logic [CW-1:0]     tx_cnt;
  logic              rx_push, rx_pop, rx_empty, rx_full;
  logic [CHAR_W-1:0] rx_head;
  logic [CW-1:0]     rx_cnt;
  logic              sel_data;
  logic              tx_on;

  uart_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .line_o  (line),
    .ctrl_o  (ctrl)
  );

  assign mask     = wlen_mask(line.wlen);
  assign wlen_o   = line.wlen;
  assign sel_data = (bus_addr_i == ADDR_W'(OFS_DATA));

  // transmit side: bus pushes, engine pops through handshake
  assign tx_push    = bus_wr_i && sel_data;
  assign tx_on      = ctrl.uart_en && ctrl.tx_en;
  assign tx_valid_o = tx_on && !tx_empty;
  assign tx_data_o  = tx_head;
  assign tx_pop     = tx_valid_o && tx_ready_i;

  uart_sync_fifo #(.WIDTH(CHAR_W), .DEPTH(DEPTH)) u_tx_q (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .single_i (!line.qen),
    .push_i   (tx_push),
    .wdata_i  (bus_wdata_i[CHAR_W-1:0] & mask),
    .pop_i    (tx_pop),
    .rdata_o  (tx_head),
    .empty_o  (tx_empty),
    .full_o   (tx_full),
    .count_o  (tx_cnt)
  );

  // receive side: a character in progress finishes even after disable
  assign rx_en_o    = ctrl.uart_en && ctrl.rx_en;
  assign rx_ready_o = !rx_full && (rx_en_o || rx_busy_i);
  assign rx_push    = rx_valid_i && rx_ready_o;
  assign rx_pop     = bus_rd_i && sel_data;

  uart_sync_fifo #(.WIDTH(CHAR_W), .DEPTH(DEPTH)) u_rx_q (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .single_i (!line.qen),
    .push_i   (rx_push),
    .wdata_i  (rx_data_i & mask),
    .pop_i    (rx_pop),
    .rdata_o  (rx_head),
    .empty_o  (rx_empty),
    .full_o   (rx_full),
    .count_o  (rx_cnt)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADDR_W'(OFS_DATA):  if (!rx_empty) bus_rdata_o[CHAR_W-1:0] = rx_head;
      ADDR_W'(OFS_FLAGS): begin
        bus_rdata_o[FLG_TX_EMPTY] = tx_empty;
        bus_rdata_o[FLG_RX_FULL]  = rx_full;
        bus_rdata_o[FLG_TX_FULL]  = tx_full;
        bus_rdata_o[FLG_RX_EMPTY] = rx_empty;
      end
      ADDR_W'(OFS_LINE): begin
        bus_rdata_o[LN_WLEN_LO +: 2] = line.wlen;
        bus_rdata_o[LN_QEN]          = line.qen;
      end
      ADDR_W'(OFS_CTRL): begin
        bus_rdata_o[CT_RX_EN]   = ctrl.rx_en;
        bus_rdata_o[CT_TX_EN]   = ctrl.tx_en;
        bus_rdata_o[CT_UART_EN] = ctrl.uart_en;
      end
      default: bus_rdata_o = '0;
    endcase
  end

  AST_TX_HANDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i && !tx_push) |=> (tx_cnt == $past(tx_cnt) - CW'(1))); // R8

  AST_RX_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ready_o) |=> !rx_empty); // R9

  AST_RX_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_valid_i && !(bus_rd_i && sel_data)) |=> (rx_cnt == $past(rx_cnt))); // R6

endmodule

// File: tb/sim_uart_fifo_path.sv
module sim_uart_fifo_path;

  localparam time CLK_PERIOD = 10ns;
  localparam logic [1:0] K_WR = 2'd0;
  localparam logic [1:0] K_RD = 2'd1;
  localparam int NV = 15;

  // {kind, addr, wdata, expected read, requirement number}
  localparam logic [77:0] VEC [NV] = '{
    {K_RD, 8'h18, 32'h0,     32'h90,  4'd1},  // R1 reset flags
    {K_RD, 8'h2C, 32'h0,     32'h0,   4'd1},  // R1
    {K_RD, 8'h30, 32'h0,     32'h0,   4'd1},  // R1
    {K_RD, 8'h00, 32'h0,     32'h0,   4'd6},  // R6 empty read
    {K_WR, 8'h2C, 32'h60,    32'h0,   4'd7},  // 8-bit, character mode
    {K_RD, 8'h2C, 32'h0,     32'h60,  4'd7},  // R7
    {K_WR, 8'h00, 32'hA5,    32'h0,   4'd4},
    {K_RD, 8'h18, 32'h0,     32'h30,  4'd4},  // R4 full after one
    {K_WR, 8'h00, 32'h3C,    32'h0,   4'd5},  // R5 dropped
    {K_WR, 8'h18, 32'hFF,    32'h0,   4'd11}, // R11 ignored
    {K_RD, 8'h18, 32'h0,     32'h30,  4'd2},  // R2
    {K_WR, 8'h30, 32'h301,   32'h0,   4'd11},
    {K_RD, 8'h30, 32'h0,     32'h301, 4'd11}, // R11
    {K_WR, 8'h40, 32'h1234,  32'h0,   4'd11},
    {K_RD, 8'h40, 32'h0,     32'h0,   4'd11}  // R11 unmapped
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_ready, rx_busy = 1'b0, rx_en;
  logic [7:0]  rx_data = '0;
  logic [1:0]  wlen;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_fifo_path u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_data_i(rx_data),
    .rx_busy_i(rx_busy), .rx_en_o(rx_en), .wlen_o(wlen)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge with the bus idle
  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, logic [31:0] exp, string tag);
    bus_addr = a; bus_rd = 1'b1;
    #1 check(tag, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tx_take(logic [7:0] exp, string tag);
    tx_ready = 1'b1;
    #1;
    check({tag, " valid"}, 32'(tx_valid), 32'd1);
    check({tag, " data"}, 32'(tx_data), 32'(exp));
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic rx_put(logic [7:0] d, logic exp_ready, string tag);
    rx_data = d; rx_valid = 1'b1;
    #1 check({tag, " ready"}, 32'(rx_ready), 32'(exp_ready));
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 R2 R4 R5 R6 R7 R11 table walk
    for (int i = 0; i < NV; i++) begin
      logic [77:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[3:0], i);
      if (v[77:76] == K_WR) bus_write(v[75:68], v[67:36]);
      else                  bus_read(v[75:68], v[35:4], tag);
    end

    // R8: enabled with one held char; dropped write never appears; empty flag after handoff
    tx_take(8'hA5, "R8 held char");
    #1 check("R8 valid after drain", 32'(tx_valid), 32'd0);
    bus_read(8'h18, 32'h90, "R8 tx empty while engine sends");

    // R3: queue mode, transmit disabled, 17 writes
    bus_write(8'h2C, 32'h70);
    bus_write(8'h30, 32'h201);
    for (int i = 0; i < 17; i++) bus_write(8'h00, 32'h10 + i);
    bus_read(8'h18, 32'h30, "R3 tx full at 16");
    #1 check("R8 no valid while tx disabled", 32'(tx_valid), 32'd0);
    bus_write(8'h30, 32'h300);
    #1 check("R8 no valid while uart disabled", 32'(tx_valid), 32'd0);
    bus_write(8'h30, 32'h301);
    for (int i = 0; i < 16; i++) tx_take(8'(8'h10 + i), "R3 tx order");
    #1 check("R5 17th write dropped", 32'(tx_valid), 32'd0);

    // R7: width truncation on transmit
    bus_write(8'h30, 32'h001);
    bus_write(8'h2C, 32'h10);
    bus_write(8'h00, 32'hFF);
    bus_write(8'h2C, 32'h30);
    #1 check("R7 wlen_o", 32'(wlen), 32'd1);
    bus_write(8'h00, 32'hFF);
    bus_write(8'h30, 32'h301);
    tx_take(8'h1F, "R7 5-bit tx");
    tx_take(8'h3F, "R7 6-bit tx");

    // R7 R9: receive, 7-bit
    bus_write(8'h2C, 32'h50);
    #1 check("R9 rx_en", 32'(rx_en), 32'd1);
    rx_put(8'hFF, 1'b1, "R9 rx accept");
    bus_read(8'h00, 32'h7F, "R7 rx zero-extend");
    bus_read(8'h18, 32'h90, "R12 pop visible next cycle");

    // R3 R9: fill receive queue
    bus_write(8'h2C, 32'h70);
    for (int i = 0; i < 16; i++) rx_put(8'(8'h40 + i), 1'b1, "R3 rx fill");
    rx_put(8'h99, 1'b0, "R9 rx full not ready");
    bus_read(8'h18, 32'hC0, "R2 rx full flag");
    for (int i = 0; i < 16; i++) bus_read(8'h00, 32'h40 + i, "R3 rx order");
    bus_read(8'h00, 32'h0, "R6 empty read zero");
    bus_read(8'h18, 32'h90, "R6 no state change");

    // R4: character mode receive
    bus_write(8'h2C, 32'h60);
    rx_put(8'h5A, 1'b1, "R4 rx one");
    rx_put(8'h5B, 1'b0, "R4 rx second blocked");
    bus_read(8'h18, 32'hC0, "R4 rx full at one");
    bus_read(8'h00, 32'h5A, "R4 rx data");

    // R10: disabled receiver finishes a character in progress
    bus_write(8'h30, 32'h101);
    #1 check("R9 rx_en off", 32'(rx_en), 32'd0);
    rx_put(8'h11, 1'b0, "R9 idle disabled");
    rx_busy = 1'b1;
    rx_put(8'h22, 1'b1, "R10 finish in progress");
    rx_busy = 1'b0;
    bus_read(8'h00, 32'h22, "R10 char kept");
    bus_read(8'h18, 32'h90, "R10 only one char");

    finish_run();
  end

endmodule